// File: doc/BRIEF.md
# Stop Mode Clock Power Sequencer

This block sits inside the clock unit of a small microcontroller and controls low-power stop. When the CPU runs its stop instruction, the CPU sends the block a one-cycle request. The block then closes the core, bus and debug clock gates, turns off the PLL and the internal reference oscillator, and asks the voltage regulator for reduced power. Two configuration bits choose the kind of stop. A pseudo-stop enable and an external-oscillator enable that are both set select pseudo stop. In pseudo stop the external oscillator keeps running, and the watchdog and periodic-timer clocks stay on if their own enables are set. Any other combination of the two bits selects full stop, which also turns off the external oscillator and those two timer clocks.

A wake event moves the block to a waking state. In that state it turns the PLL and the internal reference back on, but it keeps the clock gates closed until the PLL reports that it is ready. After a full stop, the wake forces the three clock-source selects to fixed values: the system clock comes from the PLL, and the watchdog and periodic timer run from the internal reference. After a pseudo stop, the selects keep the values they had before stop. Software writes the selects through a load port while the block is in run.

Top module: `lpstop_ctrl`

## Requirements
- R1: After reset, and whenever the block is in run, `mode_state` is 0. `pll_en`, `irc_en` and every bit of `gate_en` are 1, and `vreg_lp_req` is 0. `xosc_en` follows `osc_en_cfg`, `wdog_clk_en` follows `wdog_run_cfg` and `ptmr_clk_en` follows `ptmr_run_cfg`. `clk_sel` resets to `RST_SEL` (default 0).
- R2: In run, a `stop_req` with no wake event moves `mode_state` on the next cycle to 2 (pseudo) if `pstp_en` and `osc_en_cfg` are both 1. In every other case it moves `mode_state` to 1 (full).
- R3: In either stop state (`mode_state` 1 or 2), `pll_en`, `irc_en` and all `gate_en` bits are 0, and `vreg_lp_req` is 1.
- R4: In full stop, `xosc_en`, `wdog_clk_en` and `ptmr_clk_en` are 0.
- R5: In pseudo stop, `xosc_en` is 1, `wdog_clk_en` equals `wdog_run_cfg` and `ptmr_clk_en` equals `ptmr_run_cfg`.
- R6: A wake event in either stop state moves `mode_state` to 3 (waking) on the next cycle. While the block is waking, `pll_en` and `irc_en` are 1, all `gate_en` bits are 0 and `vreg_lp_req` is 0.
- R7: While the block is waking, `pll_ready` at 1 returns `mode_state` to 0 on the next cycle, and the gates open then. `pll_ready` at 0 keeps the block waking.
- R8: On a wake from full stop, `clk_sel` becomes 3'b100 in the same cycle that `mode_state` becomes 3. Bit 2 set means the system clock comes from the PLL. Bits 1 and 0 clear mean the watchdog and the periodic timer run from the internal reference.
- R9: On a wake from pseudo stop, `clk_sel` keeps its value from before stop.
- R10: A `stop_req` in run in the same cycle as a wake event is ignored, and `mode_state` stays 0.
- R11: In run, `sel_load` writes `sel_load_val` into `clk_sel` on the next cycle. In any other state `sel_load` has no effect.
- R12: A `stop_req` in the waking state or in a stop state does not start a new stop entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle pulse from the CPU stop instruction |
| wake_evt | input | 1 | Wake event (interrupt or auto-wake timer) |
| pstp_en | input | 1 | Pseudo-stop enable bit |
| osc_en_cfg | input | 1 | External oscillator enable bit |
| wdog_run_cfg | input | 1 | Watchdog clock enable bit |
| ptmr_run_cfg | input | 1 | Periodic-timer clock enable bit |
| pll_ready | input | 1 | PLL ready indication |
| sel_load | input | 1 | Write strobe for the clock-source selects |
| sel_load_val | input | 3 | New select value {system from PLL, watchdog from ext osc, timer from ext osc} |
| pll_en | output | 1 | PLL enable |
| irc_en | output | 1 | Internal reference oscillator enable |
| xosc_en | output | 1 | External oscillator enable |
| gate_en | output | N_GATES | Clock gate opens: bit 0 core, bit 1 bus, bit 2 debug |
| vreg_lp_req | output | 1 | Regulator reduced-power request |
| wdog_clk_en | output | 1 | Watchdog clock enable |
| ptmr_clk_en | output | 1 | Periodic-timer clock enable |
| clk_sel | output | 3 | Current clock-source selects, same bit order as sel_load_val |
| mode_state | output | 2 | 0 run, 1 full stop, 2 pseudo stop, 3 waking |

## Verification
In run, a stop request and a wake event can arrive in the same cycle. In that case entry must be dropped, and the block must not fall into a stop it would leave at once. The bench applies this collision once as a directed case. The random stimulus then raises both inputs together many times under changing configuration bits. In each case the bench checks that `mode_state` is still 0 one cycle later and that every gate stays open. A select write in the same cycle as a stop request also occurs. There the bench expects both effects: the block enters stop and the new selects are kept.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_FULL   = 2'd1,
      ST_PSEUDO = 2'd2,
      ST_WAKE   = 2'd3
   } lp_state_e;

   localparam int SEL_W = 3;
   // {system from PLL, watchdog from external osc, timer from external osc}
   localparam logic [SEL_W-1:0] SEL_AFTER_FULL = 3'b100;
endpackage

// File: rtl/lpstop_fsm.sv
module lpstop_fsm
   import lpstop_pkg::*;
#(
   parameter int WAKE_REG = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stop_req,
   input  logic      wake_evt,
   input  logic      pstp_en,
   input  logic      osc_en_cfg,
   input  logic      pll_ready,
   output lp_state_e state,
   output logic      full_exit
);
   logic      wake_int;
   lp_state_e state_nx;

   generate
      if (WAKE_REG != 0 && WAKE_REG != 1) begin : g_bad_wake
         $error("lpstop_fsm: WAKE_REG must be 0 or 1");
      end
      if (WAKE_REG == 1) begin : g_wake_q
         logic wake_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wake_q <= 1'b0;
            else        wake_q <= wake_evt;
         end
         assign wake_int = wake_q;
      end else begin : g_wake_d
         assign wake_int = wake_evt;
      end
   endgenerate

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_RUN:    if (stop_req && !wake_int)
                       state_nx = (pstp_en && osc_en_cfg) ? ST_PSEUDO : ST_FULL;
         ST_FULL,
         ST_PSEUDO: if (wake_int) state_nx = ST_WAKE;
         ST_WAKE:   if (pll_ready) state_nx = ST_RUN;
         default:   state_nx = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RUN;
      else        state <= state_nx;
   end

   assign full_exit = (state == ST_FULL) && wake_int;

   assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && stop_req && !wake_int) |=> (state == ST_FULL || state == ST_PSEUDO));
   assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && stop_req && wake_int) |=> (state == ST_RUN));
   assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_FULL || state == ST_PSEUDO) && wake_int) |=> (state == ST_WAKE));
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE && !pll_ready) |=> (state == ST_WAKE));
   assert_noreentry_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE) |=> (state == ST_WAKE || state == ST_RUN));
endmodule

// File: rtl/lpstop_sel.sv
module lpstop_sel
   import lpstop_pkg::*;
#(
   parameter logic [SEL_W-1:0] RST_SEL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [SEL_W-1:0] load_val,
   input  logic             full_exit,
   output logic [SEL_W-1:0] sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sel <= RST_SEL;
      else if (full_exit) sel <= SEL_AFTER_FULL;
      else if (load_en)   sel <= load_val;
   end

   assert_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
      full_exit |=> (sel == SEL_AFTER_FULL));
   assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_exit && !load_en) |=> $stable(sel));
endmodule

// File: rtl/lpstop_outdec.sv
module lpstop_outdec
   import lpstop_pkg::*;
#(
   parameter int N_GATES = 3
) (
   input  lp_state_e            state,
   input  logic                 osc_en_cfg,
   input  logic                 wdog_run_cfg,
   input  logic                 ptmr_run_cfg,
   output logic                 pll_en,
   output logic                 irc_en,
   output logic                 xosc_en,
   output logic [N_GATES-1:0]   gate_en,
   output logic                 vreg_lp_req,
   output logic                 wdog_clk_en,
   output logic                 ptmr_clk_en
);
   logic in_stop;
   logic timers_on;

   assign in_stop   = (state == ST_FULL) || (state == ST_PSEUDO);
   assign timers_on = (state != ST_FULL);

   assign pll_en      = !in_stop;
   assign irc_en      = !in_stop;
   assign vreg_lp_req = in_stop;
   assign xosc_en     = (state == ST_PSEUDO) ? 1'b1 :
                        (state == ST_FULL)   ? 1'b0 : osc_en_cfg;
   assign wdog_clk_en = timers_on && wdog_run_cfg;
   assign ptmr_clk_en = timers_on && ptmr_run_cfg;

   generate
      for (genvar g = 0; g < N_GATES; g++) begin : g_gate
         assign gate_en[g] = (state == ST_RUN);
      end
   endgenerate
endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
   import lpstop_pkg::*;
#(
   parameter int                N_GATES  = 3,
   parameter int                WAKE_REG = 0,
   parameter logic [SEL_W-1:0]  RST_SEL  = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stop_req,
   input  logic               wake_evt,
   input  logic               pstp_en,
   input  logic               osc_en_cfg,
   input  logic               wdog_run_cfg,
   input  logic               ptmr_run_cfg,
   input  logic               pll_ready,
   input  logic               sel_load,
   input  logic [SEL_W-1:0]   sel_load_val,
   output logic               pll_en,
   output logic               irc_en,
   output logic               xosc_en,
   output logic [N_GATES-1:0] gate_en,
   output logic               vreg_lp_req,
   output logic               wdog_clk_en,
   output logic               ptmr_clk_en,
   output logic [SEL_W-1:0]   clk_sel,
   output logic [1:0]         mode_state
);
   generate
      if (N_GATES < 3) begin : g_bad_gates
         $error("lpstop_ctrl: N_GATES must cover core, bus and debug");
      end
   endgenerate

   lp_state_e state;
   logic      full_exit;

   lpstop_fsm #(.WAKE_REG(WAKE_REG)) u_fsm (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_evt(wake_evt),
      .pstp_en(pstp_en), .osc_en_cfg(osc_en_cfg), .pll_ready(pll_ready),
      .state(state), .full_exit(full_exit)
   );

   lpstop_sel #(.RST_SEL(RST_SEL)) u_sel (
      .clk(clk), .rst_n(rst_n), .load_en(sel_load && (state == ST_RUN)),
      .load_val(sel_load_val), .full_exit(full_exit), .sel(clk_sel)
   );

   lpstop_outdec #(.N_GATES(N_GATES)) u_dec (
      .state(state), .osc_en_cfg(osc_en_cfg), .wdog_run_cfg(wdog_run_cfg),
      .ptmr_run_cfg(ptmr_run_cfg), .pll_en(pll_en), .irc_en(irc_en),
      .xosc_en(xosc_en), .gate_en(gate_en), .vreg_lp_req(vreg_lp_req),
      .wdog_clk_en(wdog_clk_en), .ptmr_clk_en(ptmr_clk_en)
   );

   assign mode_state = state;

   assert_stopgate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FULL || state == ST_PSEUDO) |-> (gate_en == '0 && vreg_lp_req && !pll_en));
   assert_fullosc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FULL) |-> (!xosc_en && !wdog_clk_en && !ptmr_clk_en));
   assert_pseudosel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PSEUDO) |=> $stable(clk_sel));
   assert_gateready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE) |-> (gate_en == '0 && pll_en && irc_en));
endmodule

// File: tb/lpstop_ctrl_bench.sv
module lpstop_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_req = 0, wake_evt = 0, pstp_en = 0, osc_en_cfg = 0;
   logic       wdog_run_cfg = 0, ptmr_run_cfg = 0, pll_ready = 0, sel_load = 0;
   logic [2:0] sel_load_val = 0;
   logic       pll_en, irc_en, xosc_en, vreg_lp_req, wdog_clk_en, ptmr_clk_en;
   logic [2:0] gate_en, clk_sel;
   logic [1:0] mode_state;

   int vectors = 0, miscomp = 0;
   int m_state = 0;
   logic [2:0] m_sel = 3'b000;
   bit done = 0;

   // values for the next applied cycle
   bit n_stop, n_wake, n_pstp, n_osc, n_wd, n_pt, n_rdy, n_ld;
   logic [2:0] n_lv;

   always #10 clk = ~clk;

   lpstop_ctrl u_lpstop_ctrl (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_evt(wake_evt),
      .pstp_en(pstp_en), .osc_en_cfg(osc_en_cfg), .wdog_run_cfg(wdog_run_cfg),
      .ptmr_run_cfg(ptmr_run_cfg), .pll_ready(pll_ready), .sel_load(sel_load),
      .sel_load_val(sel_load_val), .pll_en(pll_en), .irc_en(irc_en),
      .xosc_en(xosc_en), .gate_en(gate_en), .vreg_lp_req(vreg_lp_req),
      .wdog_clk_en(wdog_clk_en), .ptmr_clk_en(ptmr_clk_en), .clk_sel(clk_sel),
      .mode_state(mode_state)
   );

   task automatic chk(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscomp++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_state_next(int st);
      case (st)
         0: return (n_stop && !n_wake) ? ((n_pstp && n_osc) ? 2 : 1) : 0;
         1, 2: return n_wake ? 3 : st;
         default: return n_rdy ? 0 : 3;
      endcase
   endfunction

   function automatic logic [2:0] exp_sel_next(int st, logic [2:0] s);
      if (st == 1 && n_wake) return 3'b100;
      if (st == 0 && n_ld)   return n_lv;
      return s;
   endfunction

   task automatic check_outputs();
      string tag_run, tag_stop;
      bit stp;
      stp = (m_state == 1 || m_state == 2);
      tag_run  = (m_state == 0) ? "R1" : (m_state == 3) ? "R6 R7" : "R3";
      tag_stop = (m_state == 1) ? "R4" : (m_state == 2) ? "R5" : "R1";
      chk("R2 R6 R7 R10 R12", "mode_state", mode_state, m_state);
      chk(tag_run, "pll_en", pll_en, !stp);
      chk(tag_run, "irc_en", irc_en, !stp);
      chk(tag_run, "gate_en", gate_en, (m_state == 0) ? 7 : 0);
      chk(tag_run, "vreg_lp_req", vreg_lp_req, stp);
      chk(tag_stop, "xosc_en", xosc_en, (m_state == 1) ? 0 : (m_state == 2) ? 1 : osc_en_cfg);
      chk(tag_stop, "wdog_clk_en", wdog_clk_en, (m_state == 1) ? 0 : wdog_run_cfg);
      chk(tag_stop, "ptmr_clk_en", ptmr_clk_en, (m_state == 1) ? 0 : ptmr_run_cfg);
      chk("R8 R9 R11", "clk_sel", clk_sel, m_sel);
   endtask

   task automatic cyc();
      int nst;
      @(negedge clk);
      check_outputs();
      stop_req = n_stop; wake_evt = n_wake; pstp_en = n_pstp; osc_en_cfg = n_osc;
      wdog_run_cfg = n_wd; ptmr_run_cfg = n_pt; pll_ready = n_rdy;
      sel_load = n_ld; sel_load_val = n_lv;
      nst = exp_state_next(m_state);
      m_sel = exp_sel_next(m_state, m_sel);
      m_state = nst;
   endtask

   task automatic idle();
      n_stop = 0; n_wake = 0; n_rdy = 0; n_ld = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscomp++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      n_pstp = 0; n_osc = 0; n_wd = 1; n_pt = 1; n_lv = 0; idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc();                                   // R1 reset state check
      // R10: stop and wake collide in run
      n_stop = 1; n_wake = 1; cyc(); idle(); cyc(); cyc();
      // R11: load selects, then R2 pseudo entry, R5, R9 keep, R6, R7
      n_ld = 1; n_lv = 3'b011; cyc(); idle();
      n_pstp = 1; n_osc = 1; n_wd = 1; n_pt = 0;
      n_stop = 1; cyc(); idle(); cyc();
      n_stop = 1; cyc(); idle();               // R12 stop inside stop
      n_ld = 1; n_lv = 3'b111; cyc(); idle();  // R11 load ignored in stop
      n_wake = 1; cyc(); idle(); cyc();        // R6 waking, R9 selects kept
      n_stop = 1; cyc(); idle(); cyc();        // R12 stop while waking
      n_rdy = 1; cyc(); idle(); cyc();         // R7 back to run
      // R2 full entry (pseudo bit clear), R4, R8 forced selects
      n_pstp = 0; n_stop = 1; cyc(); idle(); cyc();
      n_wake = 1; cyc(); idle(); cyc(); cyc();
      n_rdy = 1; cyc(); idle(); cyc();
      // R2 full entry when oscillator bit clear
      n_pstp = 1; n_osc = 0; n_stop = 1; cyc(); idle(); cyc();
      n_wake = 1; n_rdy = 1; cyc(); idle(); n_rdy = 1; cyc(); idle(); cyc();
      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         n_stop = ($urandom_range(0, 3) == 0);
         n_wake = ($urandom_range(0, 4) == 0);
         n_rdy  = ($urandom_range(0, 2) == 0);
         n_ld   = ($urandom_range(0, 7) == 0);
         n_lv   = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 7) == 0) n_pstp = ~n_pstp;
         if ($urandom_range(0, 7) == 0) n_osc  = ~n_osc;
         if ($urandom_range(0, 9) == 0) n_wd   = ~n_wd;
         if ($urandom_range(0, 9) == 0) n_pt   = ~n_pt;
         cyc();
      end
      idle(); cyc();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end
endmodule